// File: doc/BRIEF.md
# Serial Register Control Port

This block lets a host processor program and inspect a small bank of 8-bit configuration registers over a four-wire serial link. The link has a bit clock, an active-low frame-enable line, a data line into the block and a data line out of it. Each access is one frame of 24 bits, most significant bit first. The first byte names the device and says whether the access reads or writes. The second byte picks a register and the third byte carries the value. Only frames whose device byte carries the block's own identifier are accepted. The register contents come out as a flat bus for the logic that the registers configure.

The serial pins need not share a clock with anything else. They are oversampled in the system clock domain through two-flop synchronisers, and their edges are detected there. A write takes effect when the enable line returns high after exactly 24 bit clocks. On a read, the selected register is shifted out during the third byte only. At all other times the output driver is off.

During reset the block samples its input pins as straps. If the data input, the bit clock and the enable line are all held low, the block comes up in a fixed-configuration mode. In that mode every serial frame is ignored, one clock-enable bit is forced on, and the level seen on the data-output pad picks master or slave operation for the audio clock port.

Top module: `ctrl_spi_port`

## Requirements
- R1: A frame is accepted as a write when the first byte's upper seven bits equal the device identifier (7'h04, so the byte is 8'h08), its bit 0 is 0, and the enable line rises after exactly 24 rising bit-clock edges. Register (second byte) then takes the third byte.
- R2: A frame whose first byte's upper seven bits differ from the identifier changes no register and never enables the output driver.
- R3: A frame ended by the enable line after fewer or more than 24 rising bit-clock edges changes no register.
- R4: A frame with first byte 8'h09 is a read. From the falling bit-clock edge after the 16th rising edge until the 24th rising edge, `sdo_oe` is high and `sdo` presents the addressed register MSB first, one new bit after each falling edge.
- R5: Outside the third byte of a matching read, `sdo_oe` is low. It is also low whenever the enable line is high.
- R6: A register address at or above `NREG` is ignored on write and reads back as 8'h00.
- R7: After a reset with the straps not all low, `standalone` is 0 and register i holds i*16 (truncated to 8 bits).
- R8: After a reset during which `sdi`, `sclk` and `latch_n` are all low, `standalone` is 1. Register 0 bit 7 (clock enable) is 1, register 1 bit 0 equals the level of `sdo_pad` during reset, and the other bits keep their R7 defaults. Every frame is then ignored and the driver stays off.
- R9: An accepted write changes only the addressed register. The new value is visible on `regs` within 4 system clocks of the enable line rising, and no register changes at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| sclk | input | 1 | Serial bit clock from the host |
| latch_n | input | 1 | Active-low frame enable |
| sdi | input | 1 | Serial data from the host |
| sdo_pad | input | 1 | Level seen on the data-output pad, used as a strap |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output driver enable for `sdo` |
| standalone | output | 1 | High when the fixed-configuration mode was strapped |
| regs | output | NREG*8 | Register bank, register i in bits [8i+7:8i] |

## Verification
The bench sweeps every data value through the registers and reads each one back serially. This exposes a wrong bit order or a read that is one bit late, which would show as a shifted byte. Frames of 23 and 25 bits and a bare enable blip target a bit counter that fires on "at least 24" or that wraps around; such a design would write a register it should leave alone. Frames with a foreign device byte and addresses past the bank check that the identifier and the range gate both writes and the output driver. Repeated resets with the straps low and the output pad at both levels target a mode latch that still accepts frames or that forces the wrong default bits.

// File: rtl/ctrl_spi_pkg.sv
package ctrl_spi_pkg;

    localparam int BYTE_BITS  = 8;
    localparam int FRAME_BITS = 3 * BYTE_BITS;
    localparam int HDR_BITS   = 2 * BYTE_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    // Strap-forced bit positions in fixed-configuration mode
    localparam int CKEN_REG = 0;
    localparam int CKEN_BIT = 7;
    localparam int MSTR_REG = 1;
    localparam int MSTR_BIT = 0;

    typedef logic [BYTE_BITS-1:0] byte_t;

    typedef struct packed {
        logic  vld;
        byte_t addr;
        byte_t data;
    } wr_req_t;

    function automatic byte_t reg_reset_val(input int idx, input logic sa, input logic ms);
        byte_t v;
        v = byte_t'(idx << 4);
        if (sa) begin
            if (idx == CKEN_REG) v[CKEN_BIT] = 1'b1;
            if (idx == MSTR_REG) v[MSTR_BIT] = ms;
        end
        return v;
    endfunction

endpackage

// File: rtl/ctrl_spi_sync.sv
module ctrl_spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/ctrl_spi_frame.sv
module ctrl_spi_frame
    import ctrl_spi_pkg::*;
#(
    parameter logic [6:0] CHIP_ID = 7'h04
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    standalone_i,
    input  logic    sclk_s,
    input  logic    lat_s,
    input  logic    sdi_s,
    input  byte_t   rd_data_i,
    output byte_t   rd_addr_o,
    output wr_req_t wr_o,
    output logic    sdo_o,
    output logic    sdo_oe_o
);

    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [FRAME_BITS-1:0] sh_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  sclk_d, lat_d;
    logic                  oe_q;
    byte_t                 obuf_q;

    logic sclk_rise, sclk_fall, lat_fall, lat_rise;
    logic id_hit_rd, id_hit_wr, rd_hit;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign lat_fall  = ~lat_s & lat_d;
    assign lat_rise  = lat_s & ~lat_d;

    // After 16 bits the device byte sits in sh_q[15:8]; after 24 in sh_q[23:16]
    assign id_hit_rd = (sh_q[HDR_BITS-1:BYTE_BITS+1] == CHIP_ID) && sh_q[BYTE_BITS];
    assign id_hit_wr = (sh_q[FRAME_BITS-1:HDR_BITS+1] == CHIP_ID) && !sh_q[HDR_BITS];
    assign rd_hit    = !standalone_i && id_hit_rd;
    assign rd_addr_o = sh_q[BYTE_BITS-1:0];

    always_comb begin
        wr_o.vld  = lat_rise && !standalone_i && (cnt_q == CNT_FULL) && id_hit_wr;
        wr_o.addr = sh_q[HDR_BITS-1:BYTE_BITS];
        wr_o.data = sh_q[BYTE_BITS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            sclk_d <= 1'b0;
            lat_d  <= 1'b1;
            oe_q   <= 1'b0;
            obuf_q <= '0;
        end else begin
            sclk_d <= sclk_s;
            lat_d  <= lat_s;
            if (lat_fall) begin
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else if (!lat_s) begin
                if (sclk_rise) begin
                    sh_q <= {sh_q[FRAME_BITS-2:0], sdi_s};
                    if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    if (cnt_q >= CNT_LAST) oe_q <= 1'b0;
                end else if (sclk_fall) begin
                    if (cnt_q == CNT_HDR && rd_hit) begin
                        obuf_q <= rd_data_i;
                        oe_q   <= 1'b1;
                    end else if (oe_q) begin
                        obuf_q <= {obuf_q[BYTE_BITS-2:0], 1'b0};
                    end
                end
            end else begin
                oe_q <= 1'b0;
            end
        end
    end

    assign sdo_o    = oe_q & obuf_q[BYTE_BITS-1];
    assign sdo_oe_o = oe_q;

    AST_OE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> (cnt_q >= CNT_HDR && cnt_q <= CNT_LAST)); // R4

    AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (lat_s && $past(lat_s)) |-> !oe_q); // R5

endmodule

// File: rtl/ctrl_spi_regbank.sv
module ctrl_spi_regbank
    import ctrl_spi_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    strap_sa_i,
    input  logic                    strap_ms_i,
    input  wr_req_t                 wr_i,
    input  byte_t                   rd_addr_i,
    output byte_t                   rd_data_o,
    output logic [NREG*BYTE_BITS-1:0] regs_o,
    output logic                    standalone_o
);

    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [NREG-1:0][BYTE_BITS-1:0] regs_q;
    logic                           sa_q;
    logic                           wr_en;

    assign wr_en = wr_i.vld && !sa_q && (int'(wr_i.addr) < NREG);

    always_ff @(posedge clk) begin
        if (rst) begin
            sa_q <= strap_sa_i;
            for (int i = 0; i < NREG; i++) regs_q[i] <= reg_reset_val(i, strap_sa_i, strap_ms_i);
        end else if (wr_en) begin
            regs_q[wr_i.addr[IDX_W-1:0]] <= wr_i.data;
        end
    end

    assign rd_data_o    = (int'(rd_addr_i) < NREG) ? regs_q[rd_addr_i[IDX_W-1:0]] : '0;
    assign regs_o       = regs_q;
    assign standalone_o = sa_q;

    AST_REG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(regs_q) && !$past(rst)) |-> $past(wr_i.vld)); // R9

    AST_STANDALONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (sa_q && !$past(rst)) |=> $stable(regs_q)); // R8

endmodule

// File: rtl/ctrl_spi_port.sv
module ctrl_spi_port
    import ctrl_spi_pkg::*;
#(
    parameter int         NREG        = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] CHIP_ID     = 7'h04
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sclk,
    input  logic                      latch_n,
    input  logic                      sdi,
    input  logic                      sdo_pad,
    output logic                      sdo,
    output logic                      sdo_oe,
    output logic                      standalone,
    output logic [NREG*BYTE_BITS-1:0] regs
);

    logic [2:0] pins_s;
    logic       strap_sa;
    wr_req_t    wr_req;
    byte_t      rd_addr, rd_data;

    // Straps: all three control inputs low while reset is held
    assign strap_sa = ~sdi & ~sclk & ~latch_n;

    ctrl_spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i({latch_n, sclk, sdi}),
        .q_o(pins_s)
    );

    ctrl_spi_frame #(
        .CHIP_ID(CHIP_ID)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .standalone_i(standalone),
        .sclk_s      (pins_s[1]),
        .lat_s       (pins_s[2]),
        .sdi_s       (pins_s[0]),
        .rd_data_i   (rd_data),
        .rd_addr_o   (rd_addr),
        .wr_o        (wr_req),
        .sdo_o       (sdo),
        .sdo_oe_o    (sdo_oe)
    );

    ctrl_spi_regbank #(
        .NREG(NREG)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .strap_sa_i  (strap_sa),
        .strap_ms_i  (sdo_pad),
        .wr_i        (wr_req),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .regs_o      (regs),
        .standalone_o(standalone)
    );

endmodule

// File: tb/ctrl_spi_port_tb.sv
module ctrl_spi_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 8;
    localparam int HALF       = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, latch_n = 1'b1, sdi = 1'b0, sdo_pad = 1'b0;
    logic sdo, sdo_oe, standalone;
    logic [NREG*8-1:0] regs;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] exp_regs [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctrl_spi_port #(.NREG(NREG)) dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .latch_n(latch_n), .sdi(sdi),
        .sdo_pad(sdo_pad), .sdo(sdo), .sdo_oe(sdo_oe),
        .standalone(standalone), .regs(regs)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++) check(tag, 32'(regs[i*8 +: 8]), 32'(exp_regs[i]));
    endtask

    task automatic set_defaults(input logic sa, input logic ms);
        for (int i = 0; i < NREG; i++) begin
            exp_regs[i] = 8'((i * 16) & 8'hFF);
            if (sa && i == 0) exp_regs[i][7] = 1'b1;
            if (sa && i == 1) exp_regs[i][0] = ms;
        end
    endtask

    task automatic do_reset(input logic strap_low, input logic pad);
        rst = 1'b1;
        sclk = 1'b0; sdi = 1'b0; sdo_pad = pad;
        latch_n = strap_low ? 1'b0 : 1'b1;
        tick(6);
        rst = 1'b0;
        tick(6);
    endtask

    // Shift one frame; returns the read byte and the number of bit slots
    // where sdo_oe differed from expectation.
    task automatic run_frame(input logic [23:0] word, input int nbits, input bit exp_rd,
                             output logic [7:0] rd, output int oe_bad);
        rd = '0;
        oe_bad = 0;
        latch_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 24) ? word[23-i] : 1'b0;
            tick(HALF);
            if (i < 24) begin
                if (sdo_oe !== (exp_rd && i >= 16)) oe_bad++;
                if (i >= 16) rd[23-i] = sdo;
            end
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        tick(HALF);
        latch_n = 1'b1;
        tick(4);
        if (sdo_oe !== 1'b0) oe_bad++;
        tick(4);
    endtask

    task automatic write_reg(input logic [7:0] hdr, input logic [7:0] a, input logic [7:0] d,
                             input int nbits);
        logic [7:0] rd;
        int bad;
        run_frame({hdr, a, d}, nbits, 1'b0, rd, bad);
        check("R5 no drive on write", 32'(bad), 0);
    endtask

    initial begin
        logic [7:0] rd;
        int bad;

        set_defaults(1'b0, 1'b0);
        do_reset(1'b0, 1'b1);
        check("R7 standalone low", 32'(standalone), 0);
        check("R5 oe low at reset", 32'(sdo_oe), 0);
        check_regs("R7 reset defaults");

        // R1 R9: write every register, timing of visibility
        for (int a = 0; a < NREG; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 5) & 8'hFF) ^ 8'hA5;
            run_frame({8'h08, 8'(a), d}, 24, 1'b0, rd, bad);
            exp_regs[a] = d;
            check_regs("R1 R9 write sweep");
        end

        // R9: new value visible within 4 clocks of latch rising
        latch_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < 24; i++) begin
            logic [23:0] w;
            w = {8'h08, 8'd5, 8'h3C};
            sdi = w[23-i];
            tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
        end
        tick(HALF);
        check("R9 not yet written", 32'(regs[5*8 +: 8]), 32'(exp_regs[5]));
        latch_n = 1'b1;
        tick(4);
        exp_regs[5] = 8'h3C;
        check_regs("R9 written within 4 clocks");
        tick(4);

        // R4 R5: read every register
        for (int a = 0; a < NREG; a++) begin
            run_frame({8'h09, 8'(a), 8'h00}, 24, 1'b1, rd, bad);
            check("R4 read data", 32'(rd), 32'(exp_regs[a]));
            check("R5 oe window", 32'(bad), 0);
        end
        check_regs("R1 reads leave registers");

        // R2: foreign device byte
        write_reg(8'h0A, 8'd2, 8'hEE, 24);
        write_reg(8'h00, 8'd2, 8'hEE, 24);
        write_reg(8'hFE, 8'd2, 8'hEE, 24);
        check_regs("R2 foreign id write");
        run_frame({8'h0B, 8'd2, 8'h00}, 24, 1'b0, rd, bad);
        check("R2 foreign id read no drive", 32'(bad), 0);

        // R3: short, long and empty frames
        write_reg(8'h08, 8'd3, 8'h99, 23);
        write_reg(8'h08, 8'd3, 8'h99, 25);
        write_reg(8'h08, 8'd3, 8'h99, 0);
        check_regs("R3 wrong length");

        // R6: out-of-range address
        write_reg(8'h08, 8'(NREG), 8'hFF, 24);
        write_reg(8'h08, 8'hFF, 8'hFF, 24);
        check_regs("R6 write out of range");
        run_frame({8'h09, 8'(NREG + 1), 8'h00}, 24, 1'b1, rd, bad);
        check("R6 read out of range", 32'(rd), 0);
        check("R6 oe window", 32'(bad), 0);

        // R1 R4: every data value through the bank, periodic serial readback
        for (int v = 0; v < 256; v++) begin
            int a;
            a = v % NREG;
            run_frame({8'h08, 8'(a), 8'(v)}, 24, 1'b0, rd, bad);
            exp_regs[a] = 8'(v);
            check("R1 value sweep", 32'(regs[a*8 +: 8]), 32'(v));
            if (v % 16 == 7) begin
                run_frame({8'h09, 8'(a), 8'h00}, 24, 1'b1, rd, bad);
                check("R4 sweep readback", 32'(rd), 32'(v));
                check("R5 sweep oe", 32'(bad), 0);
            end
        end
        check_regs("R9 sweep final bank");

        // R8: fixed-configuration mode, pad high then low
        set_defaults(1'b1, 1'b1);
        do_reset(1'b1, 1'b1);
        check("R8 standalone high", 32'(standalone), 1);
        check_regs("R8 strap defaults pad high");
        write_reg(8'h08, 8'd4, 8'h55, 24);
        check_regs("R8 write ignored");
        run_frame({8'h09, 8'd0, 8'h00}, 24, 1'b0, rd, bad);
        check("R8 read not driven", 32'(bad), 0);
        latch_n = 1'b0;

        set_defaults(1'b1, 1'b0);
        do_reset(1'b1, 1'b0);
        check("R8 standalone high again", 32'(standalone), 1);
        check_regs("R8 strap defaults pad low");

        // R7: back to normal mode
        set_defaults(1'b0, 1'b0);
        do_reset(1'b0, 1'b1);
        check("R7 standalone cleared", 32'(standalone), 0);
        check_regs("R7 defaults after re-reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule